// File: doc/BRIEF.md
# Calendar Time-of-Year Counter

This block keeps a running calendar: a 4-bit sub-second count, seconds, minutes, hours, day of month, month and a separate 32-bit year. A 32768 Hz tick enable drives it. A prescaler divides the tick into sixteen sub-second steps per second. Each step ripples carries through the fields within the same clock, using month lengths and a leap rule based on the year being divisible by four.

Software reaches the counter through a single-beat register port: valid, write, address and 32-bit data, with reads returned one cycle later. The time is packed into one word and the year has its own word. Each has separate write and read offsets. A control register holds a block-enable bit and an oscillator-enable bit. A small two-state machine follows them: `TOD_HALT` moves to `TOD_RUN` on a control write with both bits set, and `TOD_RUN` returns to `TOD_HALT` on a control write with either bit clear. In `TOD_HALT` the counter is frozen, the time and year words read as zero, and writes to them are dropped.

Top module: `tod_calendar`

## Requirements
- R1: After reset the control register reads 0, the machine is in `TOD_HALT`, and the calendar holds month 1, day 1, 00:00:00, sub-second 0, year 0. Once the block is enabled, that value is visible.
- R2: The control register is at offset 0x40. Bit 11 is the block enable and bit 8 is the oscillator enable. The counter runs only while both are 1. Writes to 0x40 are always accepted and take effect from the next cycle. All other control bits read back as 0.
- R3: In `TOD_HALT` the calendar fields, the year and the prescaler hold their values. Writes to 0x24 and 0x28 are ignored.
- R4: A read returns data on `rsp_rdata` one cycle after the request, and the value holds until the next read. 0x2C returns the time word, 0x30 the year and 0x40 the control register. Time and year reads return 0 in `TOD_HALT`. Any other offset returns 0.
- R5: Time word layout: month in bits 31:26 (January = 1), day of month in 25:21, hour in 20:16, minute in 15:10, second in 9:4 and sub-second in 3:0.
- R6: While running, the sub-second field advances once every TICK_DIV cycles with `tick_en` high. It steps from 15 to 0 and carries into seconds.
- R7: Seconds and minutes step from 59 (or any larger value) to 0 and carry. Hours step from 23 (or any larger value) to 0 and carry into the day.
- R8: The day steps from the month's last day to 1 and carries into the month. April, June, September and November have 30 days. February has 29 days when year bits 1:0 are 00 and 28 otherwise. Every other month value has 31.
- R9: The month steps from 12 (or any larger value) to 1 and increments the year, which wraps from 0xFFFFFFFF to 0.
- R10: A write to 0x24 while running loads every time field at once from the write data and clears the prescaler. It takes precedence over a step in the same cycle.
- R11: A write to 0x28 while running loads the year and overrides a year carry in the same cycle. It does not clear the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the 32-bit register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered, one cycle after the read request |

## Verification
The hardest situations to reach are the long carry chains: a year change, a leap-year February 29, and a year write that lands in the very cycle of a year carry. From reset these would take months of simulated ticks. The bench shrinks the prescaler division to four through the parameter. It loads times one sub-second before each boundary and counts cycles from the prescaler clear, so that the year write is issued exactly on the carry step. A cycle-accurate behavioural model predicts every read response and is compared on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int DATA_W = 32;

    // register offsets (byte addresses of 32-bit words)
    localparam logic [7:0] OFS_TIME_WR = 8'h24;
    localparam logic [7:0] OFS_YEAR_WR = 8'h28;
    localparam logic [7:0] OFS_TIME_RD = 8'h2C;
    localparam logic [7:0] OFS_YEAR_RD = 8'h30;
    localparam logic [7:0] OFS_CTRL    = 8'h40;

    // control bit positions
    localparam int CTRL_BLK_BIT = 11;
    localparam int CTRL_OSC_BIT = 8;

    // packed time word, most significant field first
    typedef struct packed {
        logic [5:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [3:0] sub;
    } tod_time_t;

    localparam tod_time_t TIME_RESET = '{mon: 6'd1, day: 5'd1, hour: 5'd0,
                                         min: 6'd0, sec: 6'd0, sub: 4'd0};

    typedef enum logic [0:0] {
        TOD_HALT = 1'b0,
        TOD_RUN  = 1'b1
    } tod_state_e;

    function automatic logic [4:0] month_days(input logic [5:0] mon, input logic leap);
        logic [4:0] n;
        unique case (mon)
            6'd2:                    n = leap ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11: n = 5'd30;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICK_DIV = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    input  logic clear,
    output logic step
);

    logic adv;
    assign adv = run && tick_en && !clear;

    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            assign step = adv;
        end else begin : g_div
            localparam int CNT_W = $clog2(TICK_DIV);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

            logic [CNT_W-1:0] cnt_q;

            assign step = adv && (cnt_q == CNT_LAST);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= '0;
                end else if (adv) begin
                    cnt_q <= step ? '0 : cnt_q + CNT_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tod_calendar_core.sv
module tod_calendar_core
    import tod_pkg::*;
#(
    parameter int YEAR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_time,
    input  tod_time_t         time_wdata,
    input  logic              load_year,
    input  logic [YEAR_W-1:0] year_wdata,
    output tod_time_t         time_q,
    output logic [YEAR_W-1:0] year_q
);

    tod_time_t         time_inc;
    logic [YEAR_W-1:0] year_inc;
    logic              leap;
    logic [4:0]        last_day;

    assign leap     = (year_q[1:0] == 2'b00);
    assign last_day = month_days(time_q.mon, leap);

    // full carry chain resolved in one cycle
    always_comb begin
        time_inc = time_q;
        year_inc = year_q;
        if (time_q.sub == 4'hF) begin
            time_inc.sub = 4'h0;
            if (time_q.sec >= 6'd59) begin
                time_inc.sec = 6'd0;
                if (time_q.min >= 6'd59) begin
                    time_inc.min = 6'd0;
                    if (time_q.hour >= 5'd23) begin
                        time_inc.hour = 5'd0;
                        if (time_q.day >= last_day) begin
                            time_inc.day = 5'd1;
                            if (time_q.mon >= 6'd12) begin
                                time_inc.mon = 6'd1;
                                year_inc     = year_q + YEAR_W'(1);
                            end else begin
                                time_inc.mon = time_q.mon + 6'd1;
                            end
                        end else begin
                            time_inc.day = time_q.day + 5'd1;
                        end
                    end else begin
                        time_inc.hour = time_q.hour + 5'd1;
                    end
                end else begin
                    time_inc.min = time_q.min + 6'd1;
                end
            end else begin
                time_inc.sec = time_q.sec + 6'd1;
            end
        end else begin
            time_inc.sub = time_q.sub + 4'h1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= TIME_RESET;
            year_q <= '0;
        end else begin
            if (load_time) begin
                time_q <= time_wdata;
            end else if (step) begin
                time_q <= time_inc;
            end
            if (load_year) begin
                year_q <= year_wdata;
            end else if (step) begin
                year_q <= year_inc;
            end
        end
    end

endmodule

// File: rtl/tod_bus_regs.sv
module tod_bus_regs
    import tod_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int YEAR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              run,
    input  logic [1:0]        ctrl_bits,
    input  tod_time_t         time_q,
    input  logic [YEAR_W-1:0] year_q,
    output logic              wr_ctrl,
    output logic              wr_time,
    output logic              wr_year,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              is_wr;
    logic              is_rd;
    logic [DATA_W-1:0] rd_mux;

    assign is_wr   = req_valid && req_write;
    assign is_rd   = req_valid && !req_write;
    assign wr_ctrl = is_wr && (req_addr == ADDR_W'(OFS_CTRL));
    assign wr_time = is_wr && (req_addr == ADDR_W'(OFS_TIME_WR));
    assign wr_year = is_wr && (req_addr == ADDR_W'(OFS_YEAR_WR));

    always_comb begin
        rd_mux = '0;
        if (req_addr == ADDR_W'(OFS_TIME_RD)) begin
            if (run) rd_mux = time_q;
        end else if (req_addr == ADDR_W'(OFS_YEAR_RD)) begin
            if (run) rd_mux = DATA_W'(year_q);
        end else if (req_addr == ADDR_W'(OFS_CTRL)) begin
            rd_mux[CTRL_BLK_BIT] = ctrl_bits[1];
            rd_mux[CTRL_OSC_BIT] = ctrl_bits[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (is_rd) begin
            rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
#(
    parameter int TICK_DIV = 2048,
    parameter int ADDR_W   = 8,
    parameter int YEAR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata
);

    tod_state_e        state_q;
    tod_state_e        state_d;
    logic [1:0]        ctrl_q;
    logic              ctrl_both;
    logic              wdata_both;
    logic              run;
    logic              load_time;
    logic              load_year;
    logic              wr_ctrl;
    logic              wr_time;
    logic              wr_year;
    logic              step;
    tod_time_t         time_q;
    logic [YEAR_W-1:0] year_q;

    assign wdata_both = req_wdata[CTRL_BLK_BIT] && req_wdata[CTRL_OSC_BIT];
    assign ctrl_both  = &ctrl_q;

    // state register and stored control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TOD_HALT;
            ctrl_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (wr_ctrl) begin
                ctrl_q <= {req_wdata[CTRL_BLK_BIT], req_wdata[CTRL_OSC_BIT]};
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOD_HALT: if (wr_ctrl && wdata_both)  state_d = TOD_RUN;
            TOD_RUN:  if (wr_ctrl && !wdata_both) state_d = TOD_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            TOD_HALT: run = 1'b0;
            TOD_RUN:  run = 1'b1;
        endcase
        load_time = wr_time && run;
        load_year = wr_year && run;
    end

    tod_bus_regs #(
        .ADDR_W (ADDR_W),
        .YEAR_W (YEAR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .run       (run),
        .ctrl_bits (ctrl_q),
        .time_q    (time_q),
        .year_q    (year_q),
        .wr_ctrl   (wr_ctrl),
        .wr_time   (wr_time),
        .wr_year   (wr_year),
        .rsp_rdata (rsp_rdata)
    );

    tod_prescaler #(
        .TICK_DIV (TICK_DIV)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .clear   (load_time),
        .step    (step)
    );

    tod_calendar_core #(
        .YEAR_W (YEAR_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_time  (load_time),
        .time_wdata (tod_time_t'(req_wdata)),
        .load_year  (load_year),
        .year_wdata (req_wdata[YEAR_W-1:0]),
        .time_q     (time_q),
        .year_q     (year_q)
    );

endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
    import tod_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int YEAR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic              run,
    input logic              ctrl_both,
    input logic              step,
    input logic              load_time,
    input logic [31:0]       time_q,
    input logic [YEAR_W-1:0] year_q
);

    // R2
    run_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run == ctrl_both);

    // R2
    step_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> run);

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(time_q) && $stable(year_q)));

    // R4
    halt_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !run &&
         (req_addr == ADDR_W'(OFS_TIME_RD) || req_addr == ADDR_W'(OFS_YEAR_RD)))
        |=> (rsp_rdata == 32'd0));

    // R6
    sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_time && time_q[3:0] != 4'hF)
        |=> (time_q[3:0] == $past(time_q[3:0]) + 4'h1));

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_time && time_q[3:0] == 4'hF && time_q[9:4] >= 6'd59)
        |=> (time_q[9:4] == 6'd0));

    // R10
    time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_time |=> (time_q == $past(req_wdata)));

endmodule

bind tod_calendar tod_calendar_chk #(
    .ADDR_W (ADDR_W),
    .YEAR_W (YEAR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .run       (run),
    .ctrl_both (ctrl_both),
    .step      (step),
    .load_time (load_time),
    .time_q    (time_q),
    .year_q    (year_q)
);

// File: tb/test_tod_calendar.sv
module test_tod_calendar;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] rsp_rdata;

    always #10 clk = ~clk;

    tod_calendar #(.TICK_DIV(DIV), .ADDR_W(8), .YEAR_W(32)) i_tod_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata)
    );

    // behavioural reference model
    int          m_mon, m_day, m_hour, m_min, m_sec, m_sub, m_pre;
    logic [31:0] m_year;
    bit          m_blk, m_osc;
    logic [31:0] exp_rd;
    string       tag = "R1";
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    function automatic int days_of(input int mon, input logic [31:0] yr);
        if (mon == 2) return (yr[1:0] == 2'b00) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pk(input int mon, input int day, input int hour,
                                       input int min, input int sec, input int sub);
        return {6'(mon), 5'(day), 5'(hour), 6'(min), 6'(sec), 4'(sub)};
    endfunction

    task automatic model_advance();
        if (m_sub == 15) begin
            m_sub = 0;
            if (m_sec >= 59) begin
                m_sec = 0;
                if (m_min >= 59) begin
                    m_min = 0;
                    if (m_hour >= 23) begin
                        m_hour = 0;
                        if (m_day >= days_of(m_mon, m_year)) begin
                            m_day = 1;
                            if (m_mon >= 12) begin
                                m_mon  = 1;
                                m_year = m_year + 32'd1;
                            end else m_mon++;
                        end else m_day++;
                    end else m_hour++;
                end else m_min++;
            end else m_sec++;
        end else m_sub++;
    endtask

    always @(posedge clk) begin
        bit run_now;
        bit stepping;
        if (!rst_n) begin
            m_mon = 1; m_day = 1; m_hour = 0; m_min = 0; m_sec = 0; m_sub = 0;
            m_pre = 0; m_year = 32'd0; m_blk = 1'b0; m_osc = 1'b0; exp_rd = 32'd0;
        end else begin
            run_now = m_blk && m_osc;
            if (req_valid && !req_write) begin
                case (req_addr)
                    8'h2C:   exp_rd = run_now ? pk(m_mon, m_day, m_hour, m_min, m_sec, m_sub) : 32'd0;
                    8'h30:   exp_rd = run_now ? m_year : 32'd0;
                    8'h40:   exp_rd = (32'(m_blk) << 11) | (32'(m_osc) << 8);
                    default: exp_rd = 32'd0;
                endcase
            end
            stepping = 1'b0;
            if (run_now && tick_en) begin
                if (m_pre == DIV - 1) begin
                    m_pre = 0;
                    stepping = 1'b1;
                end else m_pre++;
            end
            if (stepping) model_advance();
            if (req_valid && req_write) begin
                case (req_addr)
                    8'h40: begin
                        m_blk = req_wdata[11];
                        m_osc = req_wdata[8];
                    end
                    8'h24: if (run_now) begin
                        m_mon  = int'(req_wdata[31:26]);
                        m_day  = int'(req_wdata[25:21]);
                        m_hour = int'(req_wdata[20:16]);
                        m_min  = int'(req_wdata[15:10]);
                        m_sec  = int'(req_wdata[9:4]);
                        m_sub  = int'(req_wdata[3:0]);
                        m_pre  = 0;
                    end
                    8'h28: if (run_now) m_year = req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s: rsp_rdata=0x%08h expected=0x%08h", tag, rsp_rdata, exp_rd);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h40); rd(8'h2C); rd(8'h30);

        // R3: halted, writes ignored, counter frozen
        tag = "R3";
        tick_en = 1'b1;
        wr(8'h24, pk(5, 5, 5, 5, 5, 5));
        wr(8'h28, 32'd99);
        wr(8'h40, 32'h0000_0800);
        idle(10);
        rd(8'h2C);
        wr(8'h40, 32'h0000_0100);
        wr(8'h24, pk(7, 7, 7, 7, 7, 7));
        idle(6);
        rd(8'h2C); rd(8'h30);

        // R1: reset calendar visible once enabled
        tag = "R1";
        tick_en = 1'b0;
        wr(8'h40, 32'h0000_0900);
        rd(8'h2C); rd(8'h30);

        // R2: only the two enable bits are kept
        tag = "R2";
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40);

        // R6: sub-second stepping with steady and gapped ticks
        tag = "R6";
        tick_en = 1'b1;
        repeat (150) rd(8'h2C);
        for (int i = 0; i < 90; i++) begin
            tick_en = (i % 3) != 0;
            rd(8'h2C);
        end
        tick_en = 1'b1;

        // R10 / R5: full load and field layout
        tag = "R10";
        wr(8'h24, pk(3, 15, 10, 20, 30, 7));
        repeat (20) rd(8'h2C);

        // R7: second, minute and hour wrap into the day
        tag = "R7";
        wr(8'h24, pk(6, 10, 23, 59, 59, 15));
        repeat (12) rd(8'h2C);
        wr(8'h24, pk(6, 10, 4, 59, 59, 14));
        repeat (12) rd(8'h2C);

        // R8: month lengths and leap February
        tag = "R8";
        wr(8'h28, 32'd2023);
        wr(8'h24, pk(4, 30, 23, 59, 59, 15));
        repeat (8) rd(8'h2C);
        wr(8'h24, pk(2, 28, 23, 59, 59, 15));
        repeat (8) rd(8'h2C);
        wr(8'h24, pk(1, 30, 23, 59, 59, 15));
        repeat (8) rd(8'h2C);
        wr(8'h28, 32'd2024);
        wr(8'h24, pk(2, 28, 23, 59, 59, 15));
        repeat (8) rd(8'h2C);
        wr(8'h24, pk(2, 29, 23, 59, 59, 15));
        repeat (8) rd(8'h2C);

        // R9: year rollover and year wrap
        tag = "R9";
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h24, pk(12, 31, 23, 59, 59, 15));
        repeat (6) begin rd(8'h2C); rd(8'h30); end

        // R11: year write lands on the carry step
        tag = "R11";
        wr(8'h28, 32'd1000);
        rd(8'h30);
        wr(8'h24, pk(12, 31, 23, 59, 59, 15));
        rd(8'h2C); rd(8'h2C); rd(8'h2C);
        wr(8'h28, 32'd500);
        rd(8'h30); rd(8'h2C);

        // R4: unmapped offsets and write to a read-only offset
        tag = "R4";
        rd(8'h10);
        wr(8'h2C, 32'hDEAD_BEEF);
        rd(8'h2C);
        rd(8'h44);

        // R3: halt again, writes dropped, value held across re-enable
        tag = "R3";
        wr(8'h40, 32'h0000_0800);
        wr(8'h24, pk(9, 9, 9, 9, 9, 9));
        wr(8'h28, 32'd77);
        idle(20);
        wr(8'h40, 32'h0000_0900);
        rd(8'h2C); rd(8'h30);

        // R4: reads return zero while halted
        tag = "R4";
        wr(8'h40, 32'h0);
        rd(8'h2C); rd(8'h30); rd(8'h40);
        idle(3);
        finish_run();
    end

endmodule